// File: doc/BRIEF.md
# CAN FD Transceiver State Permission Controller

This block owns the operating state of one CAN FD transceiver (off, on, listen, wake capable) and keeps it consistent with the system operating mode (normal, standby, sleep, restart, fail-safe). Software requests a transceiver state by writing a configuration register. The system mode arrives on a dedicated input. Every change, from either side, is checked against a permission table before it takes effect. A change that the table forbids is dropped, and a sticky mode-error interrupt is raised. In tied operation the transceiver state follows the system mode automatically.

The block also registers the transceiver supply-good input as a status bit. It gates the effective transmitter enable so that the on state only drives while the supply is good. All outputs are registered state or simple decodes of it, so each accepted change is visible one clock after it is presented.

Transceiver states (field `xcvr_state`): XS_OFF, XS_ON, XS_LISTEN, XS_WAKE. Mode register values: SM_NORMAL, SM_STANDBY, SM_SLEEP, SM_RESTART, SM_FAILSAFE.

The transitions are:
- MODE_GO applies a new system mode. It may carry a forced state: the tied target, or the fail-safe default.
- MODE_BLOCK keeps the mode and raises the error.
- WR_GO applies a requested state.
- WR_BLOCK keeps the state and raises the error.

Top module: `xcvr_state_ctrl`

## Requirements
- R1: A write to address 0x10 carries a state request in bits [2:0], coded 0=off, 1=on, 2=listen, 3=wake capable. Bit 3 is the fail-safe default disable and bit 4 selects tied operation. Request codes 4 to 7 are rejected.
- R2: The permission table is as follows. Normal allows all four states. Standby allows off, listen and wake capable. Sleep, restart and fail-safe allow only off and wake capable. The applied state is always allowed in the applied mode.
- R3: A state request not allowed in the present mode leaves the state unchanged and sets the mode-error flag.
- R4: In independent operation, a system mode change whose target forbids the present state is blocked. Mode and state stay unchanged, and the error is set on every cycle the request is held.
- R5: In tied operation, each applied mode change forces the state to on when the target is normal, and to wake capable for any other target.
- R6: Entering fail-safe forces wake capable unless the disable bit is set. With the bit set, the R4 check applies.
- R7: The mode-error flag is sticky. Writing 1 to bit 3 of address 0x5A clears it, writing 0 there has no effect, and a set in the same cycle wins over the clear.
- R8: The supply status output equals the supply-good input one clock earlier.
- R9: The transmitter enable is high only while the state is on and the supply status is high.
- R10: A state write in the same cycle as an applied mode change is rejected with the error. System mode codes 5 to 7 are rejected with the error, and the mode is kept.
- R11: After reset the state is wake capable, the mode is standby, operation is independent with the default enabled, and the error flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| sys_mode | input | 3 | Requested system mode (0 normal, 1 standby, 2 sleep, 3 restart, 4 fail-safe) |
| supply_ok | input | 1 | Transceiver supply present and not faulted |
| xcvr_state | output | 2 | Applied transceiver state |
| mode_now | output | 3 | Applied system mode |
| tx_en | output | 1 | Effective transmitter enable |
| supply_stat | output | 1 | Registered supply status bit |
| mode_err_irq | output | 1 | Sticky mode-error interrupt |

## Verification
A wrong permission decision shows at the ports on the clock after the offending request. Either `xcvr_state` or `mode_now` moves when it should hold, or `mode_err_irq` disagrees. Because both the state and the mode are held in registers, a single bad acceptance leaves a forbidden pair visible until the next legal change. A sweep over every mode, every request code, and every start-state and target pair therefore exposes any table error within one cycle. A stale tie or disable bit shows on the first mode change after it is written.

// File: rtl/xsc_pkg.sv
package xsc_pkg;
    localparam int STATE_W = 2;
    localparam int MODE_W  = 3;
    localparam int REQ_W   = 3;

    typedef enum logic [STATE_W-1:0] {
        XS_OFF    = 2'd0,
        XS_ON     = 2'd1,
        XS_LISTEN = 2'd2,
        XS_WAKE   = 2'd3
    } xs_state_e;

    typedef enum logic [MODE_W-1:0] {
        SM_NORMAL   = 3'd0,
        SM_STANDBY  = 3'd1,
        SM_SLEEP    = 3'd2,
        SM_RESTART  = 3'd3,
        SM_FAILSAFE = 3'd4
    } sys_mode_e;
endpackage

// File: rtl/xsc_perm.sv
// Permission lookup: is request code req_i allowed in mode mode_i?
module xsc_perm
    import xsc_pkg::*;
(
    input  logic [MODE_W-1:0] mode_i,
    input  logic [REQ_W-1:0]  req_i,
    output logic              ok_o
);
    logic [STATE_W-1:0] st;
    logic               code_ok;

    assign st      = req_i[STATE_W-1:0];
    assign code_ok = (req_i[REQ_W-1:STATE_W] == '0);

    always_comb begin
        ok_o = 1'b0;
        if (code_ok) begin
            unique case (mode_i)
                SM_NORMAL:   ok_o = 1'b1;
                SM_STANDBY:  ok_o = (st != XS_ON);
                SM_SLEEP,
                SM_RESTART,
                SM_FAILSAFE: ok_o = (st == XS_OFF) || (st == XS_WAKE);
                default:     ok_o = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/xsc_irq_flag.sv
// Sticky interrupt flag, set wins over write-1-to-clear.
module xsc_irq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      flag_o <= 1'b0;
        else if (set_i)  flag_o <= 1'b1;
        else if (clr_i)  flag_o <= 1'b0;
    end
endmodule

// File: rtl/xsc_supply_mon.sv
// Registers the supply-good input into a status bit.
module xsc_supply_mon (
    input  logic clk,
    input  logic good_i,
    output logic stat_o
);
    always_ff @(posedge clk) begin
        stat_o <= good_i;
    end
endmodule

// File: rtl/xcvr_state_ctrl.sv
module xcvr_state_ctrl
    import xsc_pkg::*;
#(
    parameter int                ADDR_W     = 8,
    parameter int                DATA_W     = 8,
    parameter logic [ADDR_W-1:0] CFG_ADDR   = 8'h10,
    parameter logic [ADDR_W-1:0] IRQ_ADDR   = 8'h5A,
    parameter int                ERR_BIT    = 3,
    parameter int                FS_DIS_BIT = 3,
    parameter int                TIE_BIT    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [MODE_W-1:0] sys_mode,
    input  logic              supply_ok,
    output logic [STATE_W-1:0] xcvr_state,
    output logic [MODE_W-1:0] mode_now,
    output logic              tx_en,
    output logic              supply_stat,
    output logic              mode_err_irq
);
    localparam logic [MODE_W-1:0] MODE_MAX = MODE_W'(SM_FAILSAFE);

    xs_state_e st_q, st_d;
    sys_mode_e mode_q, mode_d;
    logic      tie_q, fsdis_q;

    logic             cfg_wr, irq_clr;
    logic [REQ_W-1:0] req_st;
    logic             mode_diff, mode_valid, fs_default;
    logic             perm_wr_ok, perm_mode_ok;
    logic             mode_go, wr_go, err_set;

    assign cfg_wr  = wr_en && (wr_addr == CFG_ADDR);
    assign irq_clr = wr_en && (wr_addr == IRQ_ADDR) && wr_data[ERR_BIT];
    assign req_st  = wr_data[REQ_W-1:0];

    assign mode_diff  = (sys_mode != mode_q);
    assign mode_valid = (sys_mode <= MODE_MAX);
    assign fs_default = (sys_mode == SM_FAILSAFE) && !fsdis_q;

    // state request checked against the applied mode
    xsc_perm u_perm_wr (
        .mode_i (mode_q),
        .req_i  (req_st),
        .ok_o   (perm_wr_ok)
    );

    // applied state checked against the requested mode
    xsc_perm u_perm_mode (
        .mode_i (sys_mode),
        .req_i  ({{(REQ_W-STATE_W){1'b0}}, st_q}),
        .ok_o   (perm_mode_ok)
    );

    // MODE_GO / MODE_BLOCK and WR_GO / WR_BLOCK decisions
    assign mode_go = mode_diff && mode_valid && (tie_q || fs_default || perm_mode_ok);
    assign wr_go   = cfg_wr && !mode_go && perm_wr_ok;
    assign err_set = (mode_diff && !mode_go) || (cfg_wr && !wr_go);

    // next-state logic
    always_comb begin
        st_d   = st_q;
        mode_d = mode_q;
        if (mode_go) begin
            mode_d = sys_mode_e'(sys_mode);
            if (tie_q) begin
                st_d = (sys_mode == SM_NORMAL) ? XS_ON : XS_WAKE;
            end else if (fs_default) begin
                st_d = XS_WAKE;
            end
        end else if (wr_go) begin
            unique case (req_st[STATE_W-1:0])
                2'd0: st_d = XS_OFF;
                2'd1: st_d = XS_ON;
                2'd2: st_d = XS_LISTEN;
                2'd3: st_d = XS_WAKE;
                default: st_d = st_q;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= XS_WAKE;
            mode_q  <= SM_STANDBY;
            tie_q   <= 1'b0;
            fsdis_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            mode_q <= mode_d;
            if (cfg_wr) begin
                tie_q   <= wr_data[TIE_BIT];
                fsdis_q <= wr_data[FS_DIS_BIT];
            end
        end
    end

    xsc_irq_flag u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (err_set),
        .clr_i  (irq_clr),
        .flag_o (mode_err_irq)
    );

    xsc_supply_mon u_supply (
        .clk    (clk),
        .good_i (supply_ok),
        .stat_o (supply_stat)
    );

    // outputs
    always_comb begin
        tx_en = 1'b0;
        unique case (st_q)
            XS_ON:     tx_en = supply_stat;
            XS_OFF,
            XS_LISTEN,
            XS_WAKE:   tx_en = 1'b0;
            default:   tx_en = 1'b0;
        endcase
    end

    assign xcvr_state = st_q;
    assign mode_now   = mode_q;
endmodule

// File: rtl/xsc_chk.sv
module xsc_chk #(
    parameter logic [7:0] IRQ_ADDR = 8'h5A,
    parameter int         ERR_BIT  = 3
) (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [7:0] wr_addr,
    input logic [7:0] wr_data,
    input logic [2:0] sys_mode,
    input logic       supply_ok,
    input logic [1:0] state,
    input logic [2:0] mode,
    input logic       tx_en,
    input logic       stat,
    input logic       err,
    input logic       tie
);
    function automatic logic allowed(input logic [2:0] m, input logic [1:0] s);
        if (m == 3'd0)      return 1'b1;
        else if (m == 3'd1) return s != 2'd1;
        else                return (s == 2'd0) || (s == 2'd3);
    endfunction

    // R2
    perm_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        allowed(mode, state));

    // R9
    tx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_en |-> (stat && state == 2'd1));

    // R5
    tied_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != $past(mode)) && $past(tie) |-> state == ((mode == 3'd0) ? 2'd1 : 2'd3));

    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(err) && !($past(wr_en) && $past(wr_addr) == IRQ_ADDR && $past(wr_data[ERR_BIT])) |-> err);

    // R8
    supply_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> stat == $past(supply_ok));

    // R10
    mode_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != $past(mode)) |-> mode == $past(sys_mode));
endmodule

bind xcvr_state_ctrl xsc_chk #(.IRQ_ADDR(8'h5A), .ERR_BIT(3)) u_xsc_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .sys_mode  (sys_mode),
    .supply_ok (supply_ok),
    .state     (xcvr_state),
    .mode      (mode_now),
    .tx_en     (tx_en),
    .stat      (supply_stat),
    .err       (mode_err_irq),
    .tie       (tie_q)
);

// File: tb/xcvr_state_ctrl_tb_top.sv
`timescale 1ns/1ps
module xcvr_state_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = 8'h00;
    logic [7:0] wr_data = 8'h00;
    logic [2:0] sys_mode = 3'd1;
    logic       supply_ok = 1'b1;
    logic [1:0] xcvr_state;
    logic [2:0] mode_now;
    logic       tx_en, supply_stat, mode_err_irq;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    xcvr_state_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .sys_mode(sys_mode), .supply_ok(supply_ok), .xcvr_state(xcvr_state),
        .mode_now(mode_now), .tx_en(tx_en), .supply_stat(supply_stat),
        .mode_err_irq(mode_err_irq)
    );

    function automatic bit allowed(input int m, input int s);
        if (s > 3)       return 0;
        if (m == 0)      return 1;
        if (m == 1)      return s != 1;
        return (s == 0) || (s == 3);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic cfg(input int tie, input int dis, input int st);
        wr(8'h10, 8'((tie << 4) | (dis << 3) | st));
    endtask

    task automatic clr_err();
        wr(8'h5A, 8'h08);
    endtask

    task automatic go_mode(input int m);
        sys_mode = 3'(m);
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 8);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        // R11 reset values
        chk("R11 state", xcvr_state, 3);
        chk("R11 mode", mode_now, 1);
        chk("R11 err", mode_err_irq, 0);
        chk("R11 tx_en", tx_en, 0);
        chk("R8 status", supply_stat, 1);

        // R1 R2 R3: every request code in every mode
        for (int m = 0; m < 5; m++) begin
            for (int s = 0; s < 8; s++) begin
                go_mode(0);
                cfg(0, 0, 3);
                go_mode(m);
                clr_err();
                cfg(0, 0, s);
                chk("R1/R2/R3 state", xcvr_state, allowed(m, s) ? s : 3);
                chk("R3 err", mode_err_irq, allowed(m, s) ? 0 : 1);
            end
        end

        // R4 R6: mode changes from each state, default enabled and disabled
        for (int d = 0; d < 2; d++) begin
            for (int s0 = 0; s0 < 4; s0++) begin
                for (int t = 1; t < 5; t++) begin
                    bit fsd, ok;
                    go_mode(0);
                    cfg(0, d, s0);
                    clr_err();
                    go_mode(t);
                    fsd = (t == 4) && (d == 0);
                    ok  = fsd || allowed(t, s0);
                    chk("R4/R6 mode", mode_now, ok ? t : 0);
                    chk("R4/R6 state", xcvr_state, fsd ? 3 : s0);
                    chk("R4 err", mode_err_irq, ok ? 0 : 1);
                end
            end
        end

        // R5 tied operation
        go_mode(0);
        cfg(1, 0, 1);
        clr_err();
        for (int t = 1; t < 5; t++) begin
            go_mode(t);
            chk("R5 tied away", xcvr_state, 3);
            go_mode(0);
            chk("R5 tied normal", xcvr_state, 1);
        end
        go_mode(2);
        cfg(1, 0, 1);
        chk("R5 tied sleep write on state", xcvr_state, 3);
        chk("R5 tied sleep write on err", mode_err_irq, 1);
        go_mode(0);
        cfg(0, 0, 3);

        // R7 sticky, write-0 no effect, clear, set wins
        clr_err();
        cfg(0, 0, 5);
        repeat (3) tick();
        chk("R7 sticky", mode_err_irq, 1);
        wr(8'h5A, 8'h00);
        chk("R7 write0 no clear", mode_err_irq, 1);
        wr(8'h5A, 8'h08);
        chk("R7 w1c", mode_err_irq, 0);
        sys_mode = 3'd6;
        wr(8'h5A, 8'h08);
        chk("R7/R10 set wins", mode_err_irq, 1);
        chk("R10 bad mode kept", mode_now, 0);
        go_mode(0);

        // R10 write colliding with applied mode change
        clr_err();
        sys_mode = 3'd2; wr_en = 1'b1; wr_addr = 8'h10; wr_data = 8'h00;
        tick();
        wr_en = 1'b0;
        chk("R10 collide mode", mode_now, 2);
        chk("R10 collide state", xcvr_state, 3);
        chk("R10 collide err", mode_err_irq, 1);

        // R4 blocked request then fixed by a legal write
        go_mode(0);
        cfg(0, 0, 1);
        clr_err();
        sys_mode = 3'd2;
        tick();
        chk("R4 pending blocked", mode_now, 0);
        chk("R4 pending err", mode_err_irq, 1);
        cfg(0, 0, 3);
        chk("R4 fix write state", xcvr_state, 3);
        tick();
        chk("R4 pending applies", mode_now, 2);
        go_mode(0);

        // R8 R9 supply and transmitter enable
        for (int s = 0; s < 4; s++) begin
            for (int g = 0; g < 2; g++) begin
                cfg(0, 0, s);
                supply_ok = g[0];
                chk("R9 before status", tx_en, (s == 1 && supply_stat) ? 1 : 0);
                tick();
                chk("R8 status", supply_stat, g);
                chk("R9 tx_en", tx_en, (s == 1 && g == 1) ? 1 : 0);
            end
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule